// File: doc/BRIEF.md
# Warp Load Request Coalescer

This block accepts one warp-wide load request. The request carries a lane address and an active bit for each lane, and each active lane reads one 4-byte word. The block finds every distinct naturally aligned 32-byte memory segment that the active lanes touch. For each such segment it issues one memory transaction, one per cycle, in ascending address order. Each transaction carries the segment base address and a mask of the lanes whose word falls inside that segment.

When the final transaction has been accepted, the block raises a one-cycle completion pulse. With it come three counts: the transactions issued, the replays (every transaction after the first), and the bytes moved across the bus. A bench or a performance model can relate these to the useful bytes of the request to judge bus utilization. The block takes a new request only after the previous one has fully finished.

Top module: `warp_coalescer`

## Requirements
- R1: Each transaction has a base address whose low 5 bits are zero. Its lane mask contains exactly the still-unserved active lanes whose address, shifted right by 5, equals the base shifted right by 5. The low 5 address bits of a lane never change which segment it joins.
- R2: A request whose active lanes touch N distinct 32-byte segments produces exactly N transactions.
- R3: Within one request, the transactions appear in strictly ascending base address order.
- R4: While `txn_valid` is high and `txn_ready` is low, the next cycle still shows `txn_valid` high with the same base and mask. A transaction counts as issued only on a cycle where `txn_valid` and `txn_ready` are both high.
- R5: `req_ready` is high only while the block is idle. A `req_valid` raised while the block is busy is ignored and changes neither the transactions nor the counts.
- R6: Inactive lanes are ignored. A request with no active lane issues no transaction and completes in the cycle after acceptance, with all three counts zero.
- R7: `done` is high for exactly one cycle: the cycle after the last transaction handshake, or the cycle after acceptance for an empty request. In that cycle `done_txns` equals N, `done_replays` equals N-1 (0 when N is 0), and `done_bytes` equals 32·N.
- R8: The lane masks of one request are pairwise disjoint, and their union equals the active mask of the request.
- R9: Bus-utilization cases behave as follows. 32 aligned consecutive words, in any lane order, give 4 transactions and 128 bytes. The same run offset by one word gives 5 transactions and 160 bytes. All lanes reading one word give 1 transaction and 32 bytes. 32 words in distinct segments give 32 transactions and 1024 bytes.
- R10: After reset, `req_ready` is high and both `txn_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Warp request offered |
| req_ready | output | 1 | Block idle, request accepted on this cycle if valid |
| req_active | input | 32 | Per-lane active bits, bit l for lane l |
| req_addr | input | 1024 | Lane byte addresses, lane l at bits [32l+31:32l] |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Memory side takes the transaction |
| txn_base | output | 32 | Segment base address, 32-byte aligned |
| txn_mask | output | 32 | Lanes served by this transaction |
| done | output | 1 | One-cycle completion pulse |
| done_txns | output | 6 | Transactions issued for the request |
| done_replays | output | 6 | Transactions beyond the first |
| done_bytes | output | 11 | Bytes moved, 32 per transaction |

## Verification
Several properties are checked on every cycle by the assertions. A stalled transaction must hold its base and mask. Bases must rise within a request. Each mask must be disjoint from the lanes already served, and the union of masks must equal the active mask at completion. The three counts must be consistent with one another. The completion pulse must last a single cycle. Which segments exist, how many there are, and which lanes belong to each depend on the address patterns, so only the bench scenarios show them. Those scenarios cover aligned, permuted, offset, broadcast, fully scattered, sparse, empty and top-of-address-space requests, under both continuous and irregular back-pressure. They also poke `req_valid` while the block is busy.

// File: rtl/coal_pkg.sv
package coal_pkg;
   typedef enum logic [1:0] {
      CS_IDLE  = 2'd0,
      CS_ISSUE = 2'd1,
      CS_DONE  = 2'd2
   } coal_state_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/coal_seg_min.sv
module coal_seg_min #(
   parameter int LANES = 32,
   parameter int SEG_W = 27
) (
   input  logic [LANES-1:0][SEG_W-1:0] lane_seg,
   input  logic [LANES-1:0]            lane_vld,
   output logic [SEG_W-1:0]            min_seg,
   output logic                        min_vld
);
   localparam int LEVELS = $clog2(LANES);

   if (!coal_pkg::is_pow2(LANES)) begin : g_bad_lanes
      $error("coal_seg_min: LANES must be a power of two");
   end

   for (genvar k = 0; k <= LEVELS; k++) begin : g_lvl
      localparam int W = LANES >> k;
      logic [W-1:0][SEG_W-1:0] seg;
      logic [W-1:0]            vld;
      if (k == 0) begin : g_leaf
         assign seg = lane_seg;
         assign vld = lane_vld;
      end else begin : g_node
         for (genvar n = 0; n < W; n++) begin : g_nd
            logic pick_lo;
            assign pick_lo = g_lvl[k-1].vld[2*n] &&
                             (!g_lvl[k-1].vld[2*n+1] ||
                              (g_lvl[k-1].seg[2*n] <= g_lvl[k-1].seg[2*n+1]));
            assign seg[n] = pick_lo ? g_lvl[k-1].seg[2*n] : g_lvl[k-1].seg[2*n+1];
            assign vld[n] = g_lvl[k-1].vld[2*n] | g_lvl[k-1].vld[2*n+1];
         end
      end
   end

   assign min_seg = g_lvl[LEVELS].seg[0];
   assign min_vld = g_lvl[LEVELS].vld[0];
endmodule

// File: rtl/coal_lane_match.sv
module coal_lane_match #(
   parameter int LANES = 32,
   parameter int SEG_W = 27
) (
   input  logic [LANES-1:0][SEG_W-1:0] lane_seg,
   input  logic [LANES-1:0]            pend,
   input  logic [SEG_W-1:0]            key,
   output logic [LANES-1:0]            hit
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign hit[l] = pend[l] && (lane_seg[l] == key);
   end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
   parameter int LANES      = 32,
   parameter int ADDR_W     = 32,
   parameter int SEG_BYTES  = 32,
   parameter int WORD_BYTES = 4,
   localparam int OFS_W  = $clog2(SEG_BYTES),
   localparam int SEG_W  = ADDR_W - OFS_W,
   localparam int CNT_W  = $clog2(LANES + 1),
   localparam int BYTE_W = $clog2(LANES * SEG_BYTES + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   output logic                      req_ready,
   input  logic [LANES-1:0]          req_active,
   input  logic [LANES*ADDR_W-1:0]   req_addr,
   output logic                      txn_valid,
   input  logic                      txn_ready,
   output logic [ADDR_W-1:0]         txn_base,
   output logic [LANES-1:0]          txn_mask,
   output logic                      done,
   output logic [CNT_W-1:0]          done_txns,
   output logic [CNT_W-1:0]          done_replays,
   output logic [BYTE_W-1:0]         done_bytes
);
   import coal_pkg::*;

   if (!is_pow2(SEG_BYTES) || !is_pow2(WORD_BYTES) || (SEG_BYTES % WORD_BYTES) != 0)
   begin : g_bad_sizes
      $error("warp_coalescer: segment and word sizes must be powers of two, word <= segment");
   end
   if (ADDR_W <= OFS_W) begin : g_bad_addr
      $error("warp_coalescer: address narrower than segment offset");
   end

   coal_state_e                 state_q;
   logic [LANES-1:0][SEG_W-1:0] seg_q;
   logic [LANES-1:0][SEG_W-1:0] seg_in;
   logic [LANES-1:0]            lane_ofs_unused;
   logic [LANES-1:0]            pend_q;
   logic [LANES-1:0]            hit;
   logic [SEG_W-1:0]            min_seg;
   logic                        min_vld;
   logic [CNT_W-1:0]            txn_cnt_q;
   logic [CNT_W-1:0]            rep_cnt_q;
   logic [BYTE_W-1:0]           byte_cnt_q;
   logic                        accept;
   logic                        issue;
   logic [LANES-1:0]            pend_next;

   for (genvar l = 0; l < LANES; l++) begin : g_split
      assign seg_in[l]          = req_addr[l*ADDR_W+OFS_W +: SEG_W];
      assign lane_ofs_unused[l] = ^req_addr[l*ADDR_W +: OFS_W];
   end

   coal_seg_min #(.LANES(LANES), .SEG_W(SEG_W)) i_min (
      .lane_seg (seg_q),
      .lane_vld (pend_q),
      .min_seg  (min_seg),
      .min_vld  (min_vld)
   );

   coal_lane_match #(.LANES(LANES), .SEG_W(SEG_W)) i_match (
      .lane_seg (seg_q),
      .pend     (pend_q),
      .key      (min_seg),
      .hit      (hit)
   );

   assign req_ready = (state_q == CS_IDLE);
   assign accept    = req_valid && req_ready;
   assign txn_valid = (state_q == CS_ISSUE) && min_vld;
   assign issue     = txn_valid && txn_ready;
   assign txn_base  = {min_seg, {OFS_W{1'b0}}};
   assign txn_mask  = hit;
   assign pend_next = pend_q & ~hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= CS_IDLE;
         pend_q     <= '0;
         seg_q      <= '0;
         txn_cnt_q  <= '0;
         rep_cnt_q  <= '0;
         byte_cnt_q <= '0;
      end else begin
         case (state_q)
            CS_IDLE: begin
               if (accept) begin
                  seg_q      <= seg_in;
                  pend_q     <= req_active;
                  txn_cnt_q  <= '0;
                  rep_cnt_q  <= '0;
                  byte_cnt_q <= '0;
                  state_q    <= (req_active == '0) ? CS_DONE : CS_ISSUE;
               end
            end
            CS_ISSUE: begin
               if (issue) begin
                  pend_q     <= pend_next;
                  txn_cnt_q  <= txn_cnt_q + 1'b1;
                  byte_cnt_q <= byte_cnt_q + BYTE_W'(SEG_BYTES);
                  if (txn_cnt_q != '0) rep_cnt_q <= rep_cnt_q + 1'b1;
                  if (pend_next == '0) state_q <= CS_DONE;
               end
            end
            default: state_q <= CS_IDLE;
         endcase
      end
   end

   assign done         = (state_q == CS_DONE);
   assign done_txns    = txn_cnt_q;
   assign done_replays = rep_cnt_q;
   assign done_bytes   = byte_cnt_q;

   // ---------------- checking state and assertions ----------------
   logic [LANES-1:0] chk_active;
   logic [LANES-1:0] chk_union;
   logic [SEG_W-1:0] chk_last_seg;
   logic             chk_has_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chk_active   <= '0;
         chk_union    <= '0;
         chk_last_seg <= '0;
         chk_has_last <= 1'b0;
      end else if (accept) begin
         chk_active   <= req_active;
         chk_union    <= '0;
         chk_has_last <= 1'b0;
      end else if (issue) begin
         chk_union    <= chk_union | txn_mask;
         chk_last_seg <= txn_base[ADDR_W-1:OFS_W];
         chk_has_last <= 1'b1;
      end
   end

   a_r4_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid && !txn_ready |=> txn_valid && $stable(txn_base) && $stable(txn_mask));

   a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid && chk_has_last |-> txn_base[ADDR_W-1:OFS_W] > chk_last_seg);

   a_r8_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |-> (txn_mask & chk_union) == '0 && txn_mask != '0);

   a_r8_cover: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> chk_union == chk_active);

   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r7_replays: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> done_replays == ((done_txns == '0) ? '0 : done_txns - 1'b1));

   a_r7_bytes: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> done_bytes == BYTE_W'(done_txns) * BYTE_W'(SEG_BYTES));

   a_r6_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
      done && chk_active == '0 |-> done_txns == '0);

   a_r5_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);
endmodule

// File: tb/test_warp_coalescer.sv
module test_warp_coalescer;
   localparam int LANES = 32;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 req_valid = 1'b0;
   logic                 req_ready;
   logic [LANES-1:0]     req_active = '0;
   logic [LANES*32-1:0]  req_addr = '0;
   logic                 txn_valid;
   logic                 txn_ready = 1'b0;
   logic [31:0]          txn_base;
   logic [LANES-1:0]     txn_mask;
   logic                 done;
   logic [5:0]           done_txns;
   logic [5:0]           done_replays;
   logic [10:0]          done_bytes;

   int checks = 0;
   int failures = 0;
   logic [15:0] lfsr = 16'hACE1;
   logic [31:0] tb_addr [LANES];

   always #2 clk = ~clk;

   warp_coalescer i_warp_coalescer (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_active(req_active), .req_addr(req_addr),
      .txn_valid(txn_valid), .txn_ready(txn_ready),
      .txn_base(txn_base), .txn_mask(txn_mask),
      .done(done), .done_txns(done_txns),
      .done_replays(done_replays), .done_bytes(done_bytes)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic run_req(input logic [LANES-1:0] act, input int mode, input bit poke);
      logic [31:0] segmap [int unsigned];
      logic [31:0] exp_base [$];
      logic [31:0] exp_mask [$];
      int unsigned k;
      int n;
      bit rdy;
      for (int l = 0; l < LANES; l++) begin
         if (act[l]) begin
            k = tb_addr[l] >> 5;
            if (!segmap.exists(k)) segmap[k] = '0;
            segmap[k] = segmap[k] | (32'h1 << l);
         end
      end
      if (segmap.first(k)) begin
         do begin
            exp_base.push_back(k << 5);
            exp_mask.push_back(segmap[k]);
         end while (segmap.next(k));
      end
      n = exp_base.size();

      @(negedge clk);
      chk(req_ready == 1'b1, "R5 idle ready", 64'(req_ready), 64'd1);
      req_valid  = 1'b1;
      req_active = act;
      for (int l = 0; l < LANES; l++) req_addr[l*32 +: 32] = tb_addr[l];
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      for (int it = 0; it < 400; it++) begin
         if (mode == 0) rdy = 1'b1;
         else begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rdy = lfsr[0] | lfsr[3];
         end
         txn_ready = rdy;
         if (exp_base.size() > 0) begin
            if (poke) begin
               req_valid  = 1'b1;
               req_active = '1;
               req_addr   = '0;
            end
            chk(txn_valid == 1'b1, "R2 txn_valid", 64'(txn_valid), 64'd1);
            chk(txn_base == exp_base[0], "R1 R3 txn_base", 64'(txn_base), 64'(exp_base[0]));
            chk(txn_mask == exp_mask[0], "R1 R8 txn_mask", 64'(txn_mask), 64'(exp_mask[0]));
            chk(done == 1'b0, "R7 early done", 64'(done), 64'd0);
            chk(req_ready == 1'b0, "R5 busy ready", 64'(req_ready), 64'd0);
            @(posedge clk);
            if (rdy) begin
               void'(exp_base.pop_front());
               void'(exp_mask.pop_front());
            end
            @(negedge clk);
         end else begin
            req_valid = 1'b0;
            chk(done == 1'b1, "R7 done pulse", 64'(done), 64'd1);
            chk(txn_valid == 1'b0, "R2 no extra txn", 64'(txn_valid), 64'd0);
            chk(done_txns == 6'(n), "R2 R6 R9 txn count", 64'(done_txns), 64'(n));
            chk(done_replays == 6'((n == 0) ? 0 : n - 1), "R7 replays",
                64'(done_replays), 64'((n == 0) ? 0 : n - 1));
            chk(done_bytes == 11'(32 * n), "R7 R9 bytes", 64'(done_bytes), 64'(32 * n));
            break;
         end
      end
      @(posedge clk);
      @(negedge clk);
      chk(done == 1'b0, "R7 pulse length", 64'(done), 64'd0);
      chk(req_ready == 1'b1, "R5 ready after done", 64'(req_ready), 64'd1);
      txn_ready = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      chk(req_ready == 1'b1, "R10 reset ready", 64'(req_ready), 64'd1);
      chk(txn_valid == 1'b0, "R10 reset txn_valid", 64'(txn_valid), 64'd0);
      chk(done == 1'b0, "R10 reset done", 64'(done), 64'd0);

      // R9 aligned consecutive words: 4 segments
      for (int l = 0; l < LANES; l++) tb_addr[l] = 32'h1000 + 4 * l;
      run_req('1, 0, 1'b0);
      // R9 permuted lane order: still 4 segments
      for (int l = 0; l < LANES; l++) tb_addr[l] = 32'h1000 + 4 * ((l * 7) % 32);
      run_req('1, 1, 1'b0);
      // R9 offset by one word: 5 segments
      for (int l = 0; l < LANES; l++) tb_addr[l] = 32'h2004 + 4 * l;
      run_req('1, 1, 1'b0);
      // R9 offset by one segment: 4 segments
      for (int l = 0; l < LANES; l++) tb_addr[l] = 32'h3020 + 4 * l;
      run_req('1, 0, 1'b0);
      // R9 broadcast of one word: 1 segment, full mask
      for (int l = 0; l < LANES; l++) tb_addr[l] = 32'h4444;
      run_req('1, 1, 1'b0);
      // R9 fully scattered, descending by lane: 32 segments, ascending issue (R3)
      for (int l = 0; l < LANES; l++) tb_addr[l] = (31 - l) * 32'h100 + 32'h8;
      run_req('1, 1, 1'b0);
      // R6 empty request
      run_req('0, 0, 1'b0);
      // R6 sparse active lanes, inactive lanes point elsewhere; R5 busy poke
      for (int l = 0; l < LANES; l++) tb_addr[l] = 32'h8000 - (l % 8) * 32'h40 + (l / 8) * 4;
      run_req(32'h0F0F_A5A5, 1, 1'b1);
      // R1 low offset bits do not split a segment; top of address space
      for (int l = 0; l < LANES; l++) tb_addr[l] = 32'hFFFF_FF80 + 4 * l + (l % 4);
      run_req('1, 1, 1'b1);
      // R4 heavy back-pressure with mixed segments
      for (int l = 0; l < LANES; l++) tb_addr[l] = ((l * 13) % 9) * 32'h20 + 32'h10000;
      run_req(32'hFFFF_0F0F, 1, 1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule